// File: doc/BRIEF.md
# Reflector Substitution Map Loader

This block holds the substitution map that is applied to a character at the turnaround point of a rotor cipher path. A 6-bit map selector is captured on each rising edge of a configuration-ready strobe. The block then copies the selected 384-bit map, one bit per clock, from an on-chip read-only map store into a shadow register. When the copy is complete, the new map replaces the active map in a single cycle. The active map is a set of 64 six-bit entries, and the returning character is translated through it with no clock in the path.

Stored maps are self-inverse, so applying a map twice gives back the original character. The store holds 21 maps. Selector values beyond the stored range load the identity map and raise a sticky error flag. The busy flag is high while a copy is in progress. During a copy the previously active map keeps translating characters. A strobe edge that arrives in the middle of a copy abandons that copy and starts again with the newly captured selector. After reset the selector is 0 and map 0 is loaded without a strobe.

Top module: `refl_map_unit`

## Requirements
- R1: While reset is held and until the first copy completes, busy_o is 1, sel_err_o is 0 and the output equals the input (identity). After reset is released, map 0 is copied without any strobe.
- R2: A copy starts only on a 0-to-1 transition of cfg_rdy_i. busy_o is still 0 at the first and second negative clock edges after the transition, and it is 1 at the third. map_sel_i is captured in the cycle the copy starts.
- R3: A copy that is not restarted keeps busy_o high for exactly 384 consecutive clock cycles. The new map is in use from the cycle in which busy_o falls.
- R4: While busy_o is high, the output follows the previously active map, which changes nothing until the copy completes.
- R5: sym_out_o = active_map[sym_in_i] and follows a change on sym_in_i with no clock edge in between.
- R6: The stored map contents are as follows. For map k in 0..2, entry x in 0..25 is (3+6k+26-x) mod 26, and entries 26..63 are x. For map k in 3..20, entry x is x XOR (((5k) mod 63)+1). The store holds map k at bit address k*384, entry 0 first and each entry MSB first.
- R7: Every map that can become active is self-inverse: map[map[x]] = x for all 64 values of x.
- R8: A captured selector of 21 or more loads the identity map, with the same 384-cycle timing, and sets sel_err_o. sel_err_o then stays 1 until reset, even after later valid loads.
- R9: A strobe edge during a copy restarts it with the new selector. busy_o stays high without a gap. The old map remains in use until the restarted copy completes, which is 384 cycles after it started. The abandoned selector is never applied.
- R10: Holding cfg_rdy_i high, or changing map_sel_i while the strobe is steady, starts no copy and leaves the active map unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_rdy_i | input | 1 | Configuration-ready strobe, asynchronous, rising edge acts |
| map_sel_i | input | 6 | Map selector, captured when a copy starts |
| sym_in_i | input | 6 | Character arriving at the turnaround |
| sym_out_o | output | 6 | Character after substitution through the active map |
| busy_o | output | 1 | Map copy in progress |
| sel_err_o | output | 1 | Sticky flag: an out-of-range selector was captured |

## Verification
A misaligned bit counter or a wrong shift order in the copy path scrambles the active map. Such a fault appears at sym_out_o as soon as busy_o falls, roughly 390 cycles after the strobe, and it usually also breaks the self-inverse property of the map. A fault in the state machine or in the restart path shows at busy_o itself: a copy longer or shorter than 384 cycles, a gap in busy_o during a restart, or a copy launched by a level rather than an edge. A premature swap of the active map shows while busy_o is still high, as the output drifting away from the old map.

// File: rtl/refl_pkg.sv
package refl_pkg;

    localparam int SYM_W      = 6;
    localparam int N_ENT      = 1 << SYM_W;
    localparam int MAP_BITS   = N_ENT * SYM_W;
    localparam int N_MAPS     = 21;
    localparam int STORE_BITS = 8192;
    localparam int ADDR_W     = $clog2(STORE_BITS);
    localparam int PHASE_W    = $clog2(SYM_W);
    localparam int N_LETTERS  = 26;
    localparam int N_HIST     = 3;

    typedef logic [SYM_W-1:0]    sym_t;
    typedef logic [MAP_BITS-1:0] map_t;

    typedef enum logic {
        LD_IDLE,
        LD_RUN
    } ld_state_e;

    typedef struct packed {
        sym_t               entry;
        logic [PHASE_W-1:0] phase;
    } ld_pos_t;

    // Content of stored map k at entry x (all maps self-inverse).
    function automatic sym_t stored_entry(input int k, input int x);
        int c;
        if (k < N_HIST) begin
            c = 3 + 6 * k;
            if (x < N_LETTERS) return sym_t'((c + N_LETTERS - x) % N_LETTERS);
            return sym_t'(x);
        end
        return sym_t'(x ^ (((5 * k) % 63) + 1));
    endfunction

    // Bit-reverse so that the entry MSB sits at the lowest bit address.
    function automatic sym_t sym_rev(input sym_t s);
        sym_t r;
        for (int i = 0; i < SYM_W; i++) r[i] = s[SYM_W-1-i];
        return r;
    endfunction

    // Entry 0 occupies the most significant slice of a map word.
    function automatic sym_t map_lookup(input map_t m, input sym_t x);
        return m[MAP_BITS-1-SYM_W*int'(x) -: SYM_W];
    endfunction

    function automatic map_t identity_map();
        map_t m;
        for (int e = 0; e < N_ENT; e++) m[MAP_BITS-1-SYM_W*e -: SYM_W] = sym_t'(e);
        return m;
    endfunction

endpackage

// File: rtl/refl_map_rom.sv
module refl_map_rom
    import refl_pkg::*;
#(
    parameter int MAPS     = N_MAPS,
    parameter int CAP_BITS = STORE_BITS,
    parameter int AW       = ADDR_W
) (
    input  logic [AW-1:0] rd_addr_i,
    output logic          rd_bit_o
);
    localparam int USED_BITS = MAPS * MAP_BITS;

    logic [CAP_BITS-1:0] rom_bits;

    for (genvar m = 0; m < MAPS; m++) begin : g_map
        for (genvar e = 0; e < N_ENT; e++) begin : g_ent
            assign rom_bits[m*MAP_BITS + e*SYM_W +: SYM_W] = sym_rev(stored_entry(m, e));
        end
    end

    if (USED_BITS < CAP_BITS) begin : g_tail
        assign rom_bits[CAP_BITS-1:USED_BITS] = '0;
    end

    assign rd_bit_o = rom_bits[rd_addr_i];

endmodule

// File: rtl/refl_strobe_edge.sv
module refl_strobe_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic strobe_i,
    output logic rise_o
);
    logic [SYNC_STAGES:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= {chain_q[SYNC_STAGES-1:0], strobe_i};
    end

    assign rise_o = chain_q[SYNC_STAGES-1] & ~chain_q[SYNC_STAGES];

endmodule

// File: rtl/refl_map_loader.sv
module refl_map_loader
    import refl_pkg::*;
#(
    parameter int MAPS = N_MAPS,
    parameter int AW   = ADDR_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start_i,
    input  sym_t          sel_i,
    output logic [AW-1:0] rom_addr_o,
    input  logic          rom_bit_i,
    output logic          busy_o,
    output logic          err_o,
    output map_t          active_o
);
    ld_state_e             state_q;
    sym_t                  idx_q;
    ld_pos_t               pos_q;
    logic [MAP_BITS-2:0]   shadow_q;
    map_t                  active_q;
    logic                  err_q;

    logic bad_idx;
    logic src_bit;
    logic last_bit;
    int   addr_full;

    assign bad_idx  = int'(idx_q) >= MAPS;
    assign last_bit = (pos_q.entry == sym_t'(N_ENT-1)) && (int'(pos_q.phase) == SYM_W-1);

    always_comb begin
        addr_full  = int'(idx_q) * MAP_BITS + int'(pos_q.entry) * SYM_W + int'(pos_q.phase);
        rom_addr_o = AW'(addr_full);
        if (bad_idx) src_bit = pos_q.entry[SYM_W-1-int'(pos_q.phase)];
        else         src_bit = rom_bit_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= LD_RUN;
            idx_q    <= '0;
            pos_q    <= '0;
            shadow_q <= '0;
            active_q <= identity_map();
            err_q    <= 1'b0;
        end else if (start_i) begin
            state_q <= LD_RUN;
            idx_q   <= sel_i;
            pos_q   <= '0;
            if (int'(sel_i) >= MAPS) err_q <= 1'b1;
        end else if (state_q == LD_RUN) begin
            shadow_q <= {shadow_q[MAP_BITS-3:0], src_bit};
            if (int'(pos_q.phase) == SYM_W-1) begin
                pos_q.phase <= '0;
                pos_q.entry <= pos_q.entry + 1'b1;
            end else begin
                pos_q.phase <= pos_q.phase + 1'b1;
            end
            if (last_bit) begin
                active_q <= {shadow_q, src_bit};
                state_q  <= LD_IDLE;
            end
        end
    end

    assign busy_o   = (state_q == LD_RUN);
    assign err_o    = err_q;
    assign active_o = active_q;

endmodule

// File: rtl/refl_map_lookup.sv
module refl_map_lookup
    import refl_pkg::*;
(
    input  map_t map_i,
    input  sym_t sym_i,
    output sym_t sym_o
);
    always_comb sym_o = map_lookup(map_i, sym_i);
endmodule

// File: rtl/refl_map_unit.sv
module refl_map_unit
    import refl_pkg::*;
#(
    parameter int MAPS        = N_MAPS,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_rdy_i,
    input  logic [SYM_W-1:0] map_sel_i,
    input  logic [SYM_W-1:0] sym_in_i,
    output logic [SYM_W-1:0] sym_out_o,
    output logic             busy_o,
    output logic             sel_err_o
);
    logic              load_start;
    logic [ADDR_W-1:0] rom_addr;
    logic              rom_bit;
    map_t              active_map;

    refl_strobe_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk      (clk),
        .rst      (rst),
        .strobe_i (cfg_rdy_i),
        .rise_o   (load_start)
    );

    refl_map_rom #(.MAPS(MAPS), .CAP_BITS(STORE_BITS), .AW(ADDR_W)) u_rom (
        .rd_addr_i (rom_addr),
        .rd_bit_o  (rom_bit)
    );

    refl_map_loader #(.MAPS(MAPS), .AW(ADDR_W)) u_load (
        .clk        (clk),
        .rst        (rst),
        .start_i    (load_start),
        .sel_i      (map_sel_i),
        .rom_addr_o (rom_addr),
        .rom_bit_i  (rom_bit),
        .busy_o     (busy_o),
        .err_o      (sel_err_o),
        .active_o   (active_map)
    );

    refl_map_lookup u_look (
        .map_i (active_map),
        .sym_i (sym_in_i),
        .sym_o (sym_out_o)
    );

endmodule

// File: rtl/refl_map_chk.sv
module refl_map_chk
    import refl_pkg::*;
#(
    parameter int MAPS = N_MAPS
) (
    input logic clk,
    input logic rst,
    input logic start,
    input sym_t sel,
    input logic busy,
    input logic err,
    input map_t active,
    input sym_t sym_in,
    input sym_t sym_out
);
    localparam int RUN_W = $clog2(MAP_BITS + 1);
    logic [RUN_W-1:0] run_q;

    always_ff @(posedge clk) begin
        if (rst || start)           run_q <= '0;
        else if (busy && run_q < RUN_W'(MAP_BITS)) run_q <= run_q + 1'b1;
    end

    // R2: a detected strobe edge always leaves a copy running
    a_r2_start_busy: assert property (@(posedge clk) disable iff (rst)
        start |=> busy);

    // R3: no copy outlasts one map length
    a_r3_busy_bound: assert property (@(posedge clk) disable iff (rst)
        busy |-> run_q < RUN_W'(MAP_BITS));

    // R3: a completed copy lasted exactly one map length
    a_r3_done_len: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> $past(run_q) == RUN_W'(MAP_BITS - 1));

    // R4: active map frozen during a copy
    a_r4_hold_map: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(active));

    // R7: active map is self-inverse on the current input
    a_r7_involution: assert property (@(posedge clk) disable iff (rst)
        !busy |-> map_lookup(active, sym_out) == sym_in);

    // R8: out-of-range selector raises the error flag
    a_r8_err_set: assert property (@(posedge clk) disable iff (rst)
        (start && int'(sel) >= MAPS) |=> err);

    // R8: error flag is sticky
    a_r8_sticky: assert property (@(posedge clk) disable iff (rst)
        $past(err) |-> err);

endmodule

bind refl_map_unit refl_map_chk #(.MAPS(MAPS)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .start   (load_start),
    .sel     (map_sel_i),
    .busy    (busy_o),
    .err     (sel_err_o),
    .active  (active_map),
    .sym_in  (sym_in_i),
    .sym_out (sym_out_o)
);

// File: tb/sim_refl_map_unit.sv
`timescale 1ns/1ps
module sim_refl_map_unit;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg = 1'b0;
    logic [5:0] sel = '0;
    logic [5:0] sym_in = '0;
    logic [5:0] sym_out;
    logic       busy;
    logic       err;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    refl_map_unit u0 (
        .clk       (clk),
        .rst       (rst),
        .cfg_rdy_i (cfg),
        .map_sel_i (sel),
        .sym_in_i  (sym_in),
        .sym_out_o (sym_out),
        .busy_o    (busy),
        .sel_err_o (err)
    );

    // Expected map contents from R6; out-of-range selectors give identity (R8)
    function automatic int exp_map(input int k, input int x);
        if (k >= 21) return x;
        if (k < 3) begin
            if (x < 26) return (3 + 6*k + 26 - x) % 26;
            return x;
        end
        return x ^ (((5*k) % 63) + 1);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic compare_map(input int k, input string req);
        int bad_x = -1;
        int bad_v = 0;
        for (int x = 0; x < 64; x++) begin
            sym_in = 6'(x);
            #0.1;
            if (bad_x < 0 && int'(sym_out) != exp_map(k, x)) begin
                bad_x = x;
                bad_v = int'(sym_out);
            end
        end
        if (bad_x < 0) chk(1'b1, req, 0, 0);
        else           chk(1'b0, req, bad_v, exp_map(k, bad_x));
    endtask

    task automatic t_reset();
        bit early;
        rst = 1'b1;
        repeat (5) @(negedge clk);
        chk(busy == 1'b1, "R1 busy in reset", int'(busy), 1);
        rst = 1'b0;
        @(negedge clk);
        chk(err == 1'b0, "R1 err after reset", int'(err), 0);
        sym_in = 6'd9; #0.1;
        chk(sym_out == 6'd9, "R1 identity during first copy", int'(sym_out), 9);
        early = busy;
        chk(early == 1'b1, "R1 first copy runs", int'(early), 1);
        for (int i = 0; i < 1000 && busy; i++) @(negedge clk);
        compare_map(0, "R1 map0 after reset");
    endtask

    task automatic t_load(input int k, input int prev_k);
        bit early_ok;
        int n;
        @(negedge clk); sel = 6'(k); cfg = 1'b1;
        @(negedge clk); early_ok = (busy == 1'b0);
        @(negedge clk); early_ok &= (busy == 1'b0);
        @(negedge clk);
        chk(busy && early_ok, "R2 start latency", int'(busy && early_ok), 1);
        n = 1;
        sym_in = 6'd7; #0.1;
        chk(int'(sym_out) == exp_map(prev_k, 7), "R4 old map while busy",
            int'(sym_out), exp_map(prev_k, 7));
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            if (busy) n++;
            else break;
        end
        chk(n == 384, "R3 copy length", n, 384);
        cfg = 1'b0;
        repeat (3) @(negedge clk);
        compare_map(k, "R6 stored map");
    endtask

    task automatic t_comb();
        sym_in = 6'd3; #0.1;
        chk(int'(sym_out) == exp_map(4, 3), "R5 comb a", int'(sym_out), exp_map(4, 3));
        sym_in = 6'd40; #0.1;
        chk(int'(sym_out) == exp_map(4, 40), "R5 comb b", int'(sym_out), exp_map(4, 40));
    endtask

    task automatic t_invol(input string req);
        int bad = 0;
        for (int x = 0; x < 64; x++) begin
            int y;
            sym_in = 6'(x); #0.1;
            y = int'(sym_out);
            sym_in = 6'(y); #0.1;
            if (int'(sym_out) != x) bad++;
        end
        chk(bad == 0, req, bad, 0);
    endtask

    task automatic t_restart(input int a, input int b, input int prev_k);
        int n = 0;
        @(negedge clk); sel = 6'(a); cfg = 1'b1;
        repeat (60) @(negedge clk);
        cfg = 1'b0;
        repeat (4) @(negedge clk);
        sym_in = 6'd11; #0.1;
        chk(int'(sym_out) == exp_map(prev_k, 11), "R9 old map before restart",
            int'(sym_out), exp_map(prev_k, 11));
        sel = 6'(b); cfg = 1'b1;
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            if (busy) n++;
            else break;
            if (i == 200) begin
                sym_in = 6'd20; #0.1;
                chk(int'(sym_out) == exp_map(prev_k, 20), "R9 old map mid restart",
                    int'(sym_out), exp_map(prev_k, 20));
            end
        end
        chk(n == 386, "R9 restarted length", n, 386);
        cfg = 1'b0;
        repeat (3) @(negedge clk);
        compare_map(b, "R9 new map after restart");
    endtask

    task automatic t_hold(input int k, input int other);
        int hits = 0;
        @(negedge clk); sel = 6'(k); cfg = 1'b1;
        repeat (3) @(negedge clk);
        for (int i = 0; i < 1000 && busy; i++) @(negedge clk);
        sel = 6'(other);
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (busy) hits++;
        end
        chk(hits == 0, "R10 level does not load", hits, 0);
        compare_map(k, "R10 map unchanged");
        cfg = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        #(4 * 100000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_invol("R7 map0 involution");
        t_load(1, 0);
        t_load(2, 1);
        t_invol("R7 map2 involution");
        t_load(7, 2);
        t_load(20, 7);
        t_invol("R7 map20 involution");
        t_load(4, 20);
        t_comb();
        chk(err == 1'b0, "R8 no error for valid selectors", int'(err), 0);
        t_load(21, 4);
        chk(err == 1'b1, "R8 error on selector 21", int'(err), 1);
        t_load(63, 21);
        t_load(5, 63);
        chk(err == 1'b1, "R8 error sticky", int'(err), 1);
        t_restart(9, 13, 5);
        t_hold(3, 17);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule